// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block lets an external I2C controller read and write a bank of 8-bit configuration registers held elsewhere on the chip. It samples the two bus lines into the local system clock, recognises START, repeated START and STOP, answers to one fixed 7-bit device address, and acknowledges each byte it receives. It drives SDA only in open-drain style: a single output enable pulls the line low.

A write transaction carries a pointer byte and then data bytes. The pointer byte selects a register index and can turn on auto-increment. Reads cannot carry a pointer. To read, the controller first sends a write that it ends right after the pointer byte, with a STOP or a repeated START. It then issues a read, which starts at the stored pointer. The pointer keeps its value between transactions. The register bank sits outside the block behind a simple port: an index, a write-data bus, a one-cycle write strobe, and read data that must follow the index within the same cycle.

Top module: `i2c_reg_slave`

## Requirements
- R1: START means SDA falls while SCL is high. A START or repeated START seen in any state restarts the address phase with the bit count cleared. STOP means SDA rises while SCL is high; it returns the block to idle with SDA released.
- R2: Only the device address 7'b1001010 is served, so the address bytes are 0x94 for a write and 0x95 for a read (bit 0 = 1 means read). Any other address gets no ACK. The rest of that transaction is ignored: no write strobe fires and SDA is never driven until the next START.
- R3: The block acknowledges every byte it receives (the matching address, the pointer byte and each write-data byte) by holding sda_oe high through the ninth SCL clock of that byte.
- R4: In the pointer byte, bit 7 is the auto-increment flag and bits 6:0 are the register index. The first data byte of a write goes to that index as one reg_we pulse lasting one system-clock cycle, with reg_addr and reg_wdata valid during the pulse.
- R5: If auto-increment is set, each further data byte in the same write goes to the next register index. If it is clear, every data byte goes to the same register and the neighbouring registers are left unchanged.
- R6: When the pointer advances from index 127 it wraps to index 0.
- R7: A read starts at the stored pointer. A write that ends after the pointer byte with STOP or with a repeated START sets that pointer. The pointer, including any advance made during an earlier read, is kept for later transactions.
- R8: Read data is sent MSB first, and each bit changes only after SCL falls. SDA is released during the controller's acknowledge slot. A controller ACK leads to one more byte: from the next index if auto-increment is set, otherwise from the same index. A NACK ends the read, and SDA stays released.
- R9: sda_oe changes only while SCL is low. After reset, sda_oe and reg_we are 0 and the pointer is index 0 with auto-increment clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 7 | Register index (the current pointer) |
| reg_wdata | output | 8 | Data byte for a register write |
| reg_we | output | 1 | One-cycle write strobe into the register bank |
| reg_rdata | input | 8 | Contents of the register at reg_addr, same cycle |

## Verification
On every cycle, the assertions check several properties: START and STOP reset the transaction state, the address ACK slot always drives the line, idle never drives it, the write strobe lasts a single cycle, the pointer wraps and holds as its flag dictates, and SDA drive never changes while SCL is high. Other behaviours appear only in full bus transactions driven by the bench's scenarios. These include the address-match decision, which register each data byte lands in, the value and order of the returned read bytes, pointer retention across an aborted write and across earlier reads, and the effect of a START that cuts a byte short.

// File: rtl/i2c_slv_pkg.sv
// Package: shared types for the I2C register-access slave.
package i2c_slv_pkg;

    // Transaction phases of the slave state machine.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

endpackage

// File: rtl/i2c_bus_sampler.sv
// Module: i2c_bus_sampler
// Brings SCL and SDA into the system clock through a flip-flop chain and
// reports SCL edges plus START/STOP conditions as one-cycle pulses.
// Assumes the system clock is at least 8x the SCL rate and the lines idle high.
module i2c_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES;

    // Stage [k][1] carries SCL, [k][0] carries SDA; the final stage is the previous value.
    logic [LAST:0][1:0] pipe;

    // Shift both lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[LAST-1:0], {scl_i, sda_i}};
    end

    logic scl_p, sda_p;
    assign scl_s = pipe[LAST-1][1];
    assign sda_s = pipe[LAST-1][0];
    assign scl_p = pipe[LAST][1];
    assign sda_p = pipe[LAST][0];

    // Edge and bus-condition decode on the synchronised lines.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_ptr_reg.sv
// Module: i2c_ptr_reg
// Holds the register pointer and its auto-increment flag. A load takes both
// from the pointer byte; a step advances the index (wrapping) only when the
// flag is set. Assumes load and step never coincide.
module i2c_ptr_reg #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_inc,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             auto_inc
);
    // Pointer update: load from the pointer byte, or advance when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            auto_inc <= 1'b0;
        end else if (load) begin
            idx      <= load_idx;
            auto_inc <= load_inc;
        end else if (step && auto_inc) begin
            idx <= idx + 1'b1;
        end
    end

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && auto_inc && (idx == {IDX_W{1'b1}})) |=> (idx == '0));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !auto_inc) |=> $stable(idx));

    assert_ptr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx == $past(load_idx)));
endmodule

// File: rtl/i2c_reg_slave.sv
// Module: i2c_reg_slave
// I2C slave giving a controller byte access to an external register bank.
// Write: address, pointer byte (bit 7 auto-increment, low bits index), data.
// Read: data from the stored pointer. SDA is open-drain via sda_oe.
// Assumes reg_rdata follows reg_addr combinationally and clk >= 8x SCL.
module i2c_reg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1001010,
    parameter int         IDX_W       = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [IDX_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata
);
    import i2c_slv_pkg::*;

    localparam int         BYTE_W   = 8;
    localparam logic [3:0] BYTE_END = 4'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    slv_state_e        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_bit;
    logic              nack_seen;
    logic              ptr_load, ptr_step, auto_inc;

    // Pointer strobes: load at the end of the pointer byte, step after each
    // written byte's ACK and on a controller ACK during a read.
    always_comb begin
        ptr_load = scl_fall && (state == ST_PTR) && (bit_cnt == BYTE_END);
        ptr_step = (scl_fall && (state == ST_WDATA_ACK)) ||
                   (scl_rise && (state == ST_RACK) && !sda_s);
    end

    i2c_ptr_reg #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_inc (shreg[BYTE_W-1]),
        .load_idx (shreg[IDX_W-1:0]),
        .step     (ptr_step),
        .idx      (reg_addr),
        .auto_inc (auto_inc)
    );

    // Transaction state machine: bit shifting, ACK drive and read data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            rw_bit    <= 1'b0;
            nack_seen <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (bit_cnt < BYTE_END) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (bit_cnt < BYTE_END) bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_RACK:  nack_seen <= sda_s;
                    default: ;
                endcase
            end else if (scl_fall) begin
                unique case (state)
                    ST_ADDR: begin
                        if (bit_cnt == BYTE_END) begin
                            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                rw_bit <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_PTR: begin
                        if (bit_cnt == BYTE_END) begin
                            sda_oe <= 1'b1;
                            state  <= ST_PTR_ACK;
                        end
                    end
                    ST_WDATA: begin
                        if (bit_cnt == BYTE_END) begin
                            sda_oe    <= 1'b1;
                            reg_we    <= 1'b1;
                            reg_wdata <= shreg;
                            state     <= ST_WDATA_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (rw_bit) begin
                            shreg  <= {reg_rdata[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~reg_rdata[BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (bit_cnt == BYTE_END) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~shreg[BYTE_W-1];
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        bit_cnt <= '0;
                        if (nack_seen) begin
                            state <= ST_IDLE;
                        end else begin
                            shreg  <= {reg_rdata[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~reg_rdata[BYTE_W-1];
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == 4'd0 && !sda_oe));

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_addr_ack_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> sda_oe);

    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

// File: tb/i2c_reg_slave_tb.sv
// Directed bench for i2c_reg_slave: a bus controller model, a register bank
// model and an independent expected-contents array.
module i2c_reg_slave_tb;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       sda_line;

    logic [7:0] regs     [128];
    logic [7:0] exp_regs [128];
    int         wr_cnt = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    int         r9_viol = 0;
    logic       oe_q = 1'b0;
    logic       timed_out = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_reg_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 3 + 1) & 8'hFF);
    endfunction

    // Register bank model.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) regs[i] <= init_val(i);
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            wr_cnt         <= wr_cnt + 1;
        end
    end

    // R9 monitor: SDA drive may change only while SCL is low.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_q) && scl) r9_viol++;
        oe_q = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; wq(Q);
        m_sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(2 * Q);
        scl = 1'b1; wq(2 * Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq(2 * Q);
        scl = 1'b1; wq(Q);
        acked = ~sda_line;
        wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(2 * Q);
            scl = 1'b1; wq(Q);
            d[i] = sda_line;
            wq(Q);
            scl = 1'b0; wq(Q);
        end
        m_sda = ~give_ack; wq(2 * Q);
        scl = 1'b1; wq(Q);
        chk("R8 slave released in ack slot", sda_oe, 1'b0);
        wq(Q);
        scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk("R9 reset sda_oe", sda_oe, 1'b0);
        chk("R9 reset reg_we", reg_we, 1'b0);
        chk("R9 reset pointer", reg_addr, 7'd0);
    endtask

    task automatic t_bad_addr();
        logic a;
        int   w0;
        w0 = wr_cnt;
        bus_start();
        write_byte(8'h90, a);
        chk("R2 wrong address not acked", a, 1'b0);
        write_byte(8'h05, a);
        chk("R2 later byte ignored", a, 1'b0);
        write_byte(8'hAA, a);
        bus_stop();
        chk("R2 no write strobe", wr_cnt, w0);
        chk("R2 register 0x05 kept", regs[5], exp_regs[5]);
    endtask

    task automatic t_write_inc();
        logic a;
        bus_start();
        write_byte(8'h94, a); chk("R3 ack write address", a, 1'b1);
        write_byte(8'h90, a); chk("R3 ack pointer", a, 1'b1);
        write_byte(8'hA1, a); chk("R3 ack data 0", a, 1'b1);
        write_byte(8'hB2, a); chk("R3 ack data 1", a, 1'b1);
        write_byte(8'hC3, a); chk("R3 ack data 2", a, 1'b1);
        bus_stop();
        exp_regs[16] = 8'hA1; exp_regs[17] = 8'hB2; exp_regs[18] = 8'hC3;
        chk("R4 first byte at index", regs[16], exp_regs[16]);
        chk("R5 second byte next index", regs[17], exp_regs[17]);
        chk("R5 third byte next index", regs[18], exp_regs[18]);
        chk("R5 index past end kept", regs[19], exp_regs[19]);
        chk("R1 released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_write_noinc();
        logic a;
        bus_start();
        write_byte(8'h94, a);
        write_byte(8'h20, a);
        write_byte(8'h11, a);
        write_byte(8'h22, a);
        bus_stop();
        exp_regs[32] = 8'h22;
        chk("R5 no-inc last byte wins", regs[32], exp_regs[32]);
        chk("R5 no-inc neighbour kept", regs[33], exp_regs[33]);
    endtask

    task automatic t_wrap();
        logic a;
        bus_start();
        write_byte(8'h94, a);
        write_byte(8'hFF, a);
        write_byte(8'h5A, a);
        write_byte(8'h6B, a);
        bus_stop();
        exp_regs[127] = 8'h5A; exp_regs[0] = 8'h6B;
        chk("R6 byte at index 127", regs[127], exp_regs[127]);
        chk("R6 wrapped to index 0", regs[0], exp_regs[0]);
    endtask

    task automatic t_read_inc();
        logic       a;
        logic [7:0] d;
        bus_start();
        write_byte(8'h94, a);
        write_byte(8'h90, a);
        bus_stop();
        bus_start();
        write_byte(8'h95, a); chk("R3 ack read address", a, 1'b1);
        read_byte(1'b1, d); chk("R7 read starts at pointer", d, exp_regs[16]);
        read_byte(1'b1, d); chk("R8 auto-inc next byte", d, exp_regs[17]);
        read_byte(1'b0, d); chk("R8 auto-inc third byte", d, exp_regs[18]);
        wq(Q);
        chk("R8 released after nack", sda_oe, 1'b0);
        bus_stop();
        bus_start();
        write_byte(8'h95, a);
        read_byte(1'b0, d); chk("R7 pointer kept across reads", d, exp_regs[18]);
        bus_stop();
    endtask

    task automatic t_read_rs_noinc();
        logic       a;
        logic [7:0] d;
        bus_start();
        write_byte(8'h94, a);
        write_byte(8'h20, a);
        bus_start();
        write_byte(8'h95, a);
        read_byte(1'b1, d); chk("R7 pointer set before repeated start", d, exp_regs[32]);
        read_byte(1'b0, d); chk("R8 no-inc repeats same register", d, exp_regs[32]);
        bus_stop();
    endtask

    task automatic t_midstart();
        logic       a;
        logic [7:0] d;
        int         w0;
        w0 = wr_cnt;
        bus_start();
        write_byte(8'h94, a);
        write_byte(8'h83, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        write_byte(8'h95, a); chk("R1 address phase after cut byte", a, 1'b1);
        read_byte(1'b0, d); chk("R1 read after cut byte", d, exp_regs[3]);
        bus_stop();
        chk("R1 cut byte not written", wr_cnt, w0);
    endtask

    task automatic run_all();
        t_reset();
        t_bad_addr();
        t_write_inc();
        t_write_noinc();
        t_wrap();
        t_read_inc();
        t_read_rs_noinc();
        t_midstart();
        chk("R9 no drive change while SCL high", r9_viol, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) exp_regs[i] = init_val(i);
        wq(4);
        rst_n = 1'b1;
        wq(4);
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule